// File: doc/BRIEF.md
# Real-Mode Linear Address Generator

This block turns a memory operand description into a 20-bit linear address in the real-mode manner. The operand description has five parts: an addressing mode code, up to two general register selects with their 32-bit values, a 16-bit displacement and a scale code. The block forms a 16-bit offset from these parts. It then picks a segment, either the default implied by the registers used or an explicit override, and adds the segment value shifted left by four bits to the offset.

One request is accepted every clock cycle. The result appears on registered outputs one cycle later, so it can sit directly between an operand decoder and a memory port. A register choice that the selected mode does not permit raises an illegal-combination flag and zeroes the address outputs. An unknown mode or override code does the same.

Top module: `rm_linaddr_gen`

## Requirements
- R1: The linear address equals (segment value × 16) + offset, truncated to 20 bits. It appears on the outputs on the clock edge after the inputs are presented.
- R2: Only the low 16 bits of each 32-bit register value take part in the offset. The upper 16 bits have no effect.
- R3: Mode codes and offsets: 0 = constant only (offset = displacement), 1 = one register, 2 = base + index, 3 = register + displacement, 4 = base + index + displacement, 5 = base + index × scale.
- R4: Register select codes are AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7. Modes 1 and 3 accept only BX, BP, SI or DI in the base field.
- R5: Modes 2 and 4 accept only BX or BP as the base and only SI or DI as the index.
- R6: In mode 5, scale codes 0..3 multiply the index by 1, 2, 4 or 8. Any register may be the base, and any register except SP may be the index.
- R7: Segment codes are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. With no override, the segment is SS when BP is in the base field of modes 1–5 or in the index field of mode 5. Otherwise it is DS.
- R8: A valid override selects its segment code in place of the default, including when BP is used. Override codes 6 and 7 are illegal.
- R9: The offset sum wraps modulo 65536.
- R10: An illegal combination, or mode code 6 or 7, gives illegal flag 1 with offset, segment code and linear address all 0.
- R11: While reset is high, every output is 0 on the following edge.
- R12: In mode 0 the register selects and values have no effect, and the default segment is DS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Addressing mode code |
| base_sel_i | input | 3 | Base (or sole) register select |
| base_val_i | input | 32 | Base register value |
| idx_sel_i | input | 3 | Index register select |
| idx_val_i | input | 32 | Index register value |
| disp_i | input | 16 | Displacement |
| scale_i | input | 2 | Scale code for mode 5 |
| ovr_valid_i | input | 1 | Segment override present |
| ovr_seg_i | input | 3 | Override segment code |
| seg_es_i | input | 16 | ES value |
| seg_cs_i | input | 16 | CS value |
| seg_ss_i | input | 16 | SS value |
| seg_ds_i | input | 16 | DS value |
| seg_fs_i | input | 16 | FS value |
| seg_gs_i | input | 16 | GS value |
| ea_o | output | 16 | Registered effective offset |
| seg_o | output | 3 | Registered segment code used |
| lin_o | output | 20 | Registered linear address |
| illegal_o | output | 1 | Registered illegal-combination flag |

## Verification
Two functions can act on one request in the same cycle: the stack-segment default implied by BP and an explicit override. The bench provokes this by sending BP-based offsets together with a CS override. It judges the result by checking that the segment code and the linear address follow the override, while the offset stays the BP-derived value. Offset wrap and linear wrap are also made to meet. A request near FFFFH:0020H must wrap the 20-bit sum while the offset stays exact.

// File: rtl/rmag_pkg.sv
package rmag_pkg;

    localparam int OFS_W     = 16;
    localparam int REG_W     = 32;
    localparam int SEG_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int NSEG      = 6;

    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_REG_IND  = 3'd1,
        AM_BASE_IDX = 3'd2,
        AM_REG_DISP = 3'd3,
        AM_BIX_DISP = 3'd4,
        AM_SCALED   = 3'd5
    } amode_e;

    typedef enum logic [2:0] {
        GR_AX = 3'd0, GR_CX = 3'd1, GR_DX = 3'd2, GR_BX = 3'd3,
        GR_SP = 3'd4, GR_BP = 3'd5, GR_SI = 3'd6, GR_DI = 3'd7
    } greg_e;

    typedef enum logic [2:0] {
        SG_ES = 3'd0, SG_CS = 3'd1, SG_SS = 3'd2,
        SG_DS = 3'd3, SG_FS = 3'd4, SG_GS = 3'd5
    } sreg_e;

    typedef struct packed {
        logic [2:0] mode;
        greg_e      base;
        greg_e      idx;
        logic [1:0] scale;
    } ea_ctl_t;

    // registers usable alone as an address pointer
    function automatic logic is_ptr_reg(greg_e r);
        return (r == GR_BX) || (r == GR_BP) || (r == GR_SI) || (r == GR_DI);
    endfunction

    function automatic logic is_base_reg(greg_e r);
        return (r == GR_BX) || (r == GR_BP);
    endfunction

    function automatic logic is_idx_reg(greg_e r);
        return (r == GR_SI) || (r == GR_DI);
    endfunction

    function automatic logic seg_code_ok(logic [2:0] c);
        return int'(c) < NSEG;
    endfunction

endpackage

// File: rtl/rmag_ofs_unit.sv
module rmag_ofs_unit
    import rmag_pkg::*;
#(
    parameter int P_OFS_W = OFS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  ea_ctl_t            ctl,
    input  logic [P_OFS_W-1:0] base_lo,
    input  logic [P_OFS_W-1:0] idx_lo,
    input  logic [P_OFS_W-1:0] disp,
    output logic [P_OFS_W-1:0] ea,
    output logic               bad,
    output logic               bp_used
);

    logic [P_OFS_W-1:0] idx_scaled;

    always_comb begin
        idx_scaled = idx_lo << ctl.scale;
        ea         = '0;
        bad        = 1'b0;
        bp_used    = 1'b0;
        case (ctl.mode)
            AM_DIRECT: begin
                ea = disp;
            end
            AM_REG_IND: begin
                ea      = base_lo;
                bad     = !is_ptr_reg(ctl.base);
                bp_used = (ctl.base == GR_BP);
            end
            AM_REG_DISP: begin
                ea      = base_lo + disp;
                bad     = !is_ptr_reg(ctl.base);
                bp_used = (ctl.base == GR_BP);
            end
            AM_BASE_IDX: begin
                ea      = base_lo + idx_lo;
                bad     = !is_base_reg(ctl.base) || !is_idx_reg(ctl.idx);
                bp_used = (ctl.base == GR_BP);
            end
            AM_BIX_DISP: begin
                ea      = base_lo + idx_lo + disp;
                bad     = !is_base_reg(ctl.base) || !is_idx_reg(ctl.idx);
                bp_used = (ctl.base == GR_BP);
            end
            AM_SCALED: begin
                ea      = base_lo + idx_scaled;
                bad     = (ctl.idx == GR_SP);
                bp_used = (ctl.base == GR_BP) || (ctl.idx == GR_BP);
            end
            default: begin
                bad = 1'b1;
            end
        endcase
    end

    // R12: constant-only mode is always legal and passes the displacement
    p_direct_disp_r12: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == AM_DIRECT) |-> (ea == disp && !bad && !bp_used));

    // R4: single-register modes reject non-pointer registers
    p_ptr_only_r4: assert property (@(posedge clk) disable iff (rst)
        ((ctl.mode == AM_REG_IND || ctl.mode == AM_REG_DISP) &&
         (ctl.base == GR_AX || ctl.base == GR_SP)) |-> bad);

endmodule

// File: rtl/rmag_seg_pick.sv
module rmag_seg_pick
    import rmag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bp_used,
    input  logic       ovr_valid,
    input  logic [2:0] ovr_code,
    output logic [2:0] seg_code,
    output logic       bad
);

    always_comb begin
        bad = 1'b0;
        if (ovr_valid) begin
            seg_code = ovr_code;
            bad      = !seg_code_ok(ovr_code);
        end else if (bp_used) begin
            seg_code = SG_SS;
        end else begin
            seg_code = SG_DS;
        end
    end

    // R7: without override or stack pointer use the data segment is taken
    p_default_ds_r7: assert property (@(posedge clk) disable iff (rst)
        (!ovr_valid && !bp_used) |-> (seg_code == SG_DS && !bad));

    // R8: a legal override is never rejected
    p_ovr_legal_r8: assert property (@(posedge clk) disable iff (rst)
        (ovr_valid && ovr_code < 3'd6) |-> !bad);

endmodule

// File: rtl/rmag_lin_add.sv
module rmag_lin_add
    import rmag_pkg::*;
#(
    parameter int P_OFS_W     = OFS_W,
    parameter int P_SEG_W     = SEG_W,
    parameter int P_SEG_SHIFT = SEG_SHIFT,
    parameter int P_NSEG      = NSEG
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [P_NSEG*P_SEG_W-1:0]     seg_flat,
    input  logic [2:0]                    seg_code,
    input  logic [P_OFS_W-1:0]            ea,
    output logic [P_SEG_W+P_SEG_SHIFT-1:0] lin
);

    localparam int LIN_W = P_SEG_W + P_SEG_SHIFT;

    logic [P_SEG_W-1:0] seg_arr [P_NSEG];
    logic [P_SEG_W-1:0] seg_val;
    logic [LIN_W-1:0]   seg_base;
    logic [LIN_W-1:0]   ofs_ext;

    for (genvar g = 0; g < P_NSEG; g++) begin : g_seg_unpack
        assign seg_arr[g] = seg_flat[g*P_SEG_W +: P_SEG_W];
    end

    always_comb begin
        seg_val = '0;
        for (int k = 0; k < P_NSEG; k++) begin
            if (int'(seg_code) == k) seg_val = seg_arr[k];
        end
        seg_base = {seg_val, {P_SEG_SHIFT{1'b0}}};
        ofs_ext  = LIN_W'(ea);
        lin      = seg_base + ofs_ext;
    end

    // R1: the shifted base has zero low bits, so the low bits pass straight from the offset
    p_low_bits_r1: assert property (@(posedge clk) disable iff (rst)
        lin[P_SEG_SHIFT-1:0] == ea[P_SEG_SHIFT-1:0]);

endmodule

// File: rtl/rm_linaddr_gen.sv
module rm_linaddr_gen
    import rmag_pkg::*;
#(
    parameter int P_OFS_W     = OFS_W,
    parameter int P_REG_W     = REG_W,
    parameter int P_SEG_W     = SEG_W,
    parameter int P_SEG_SHIFT = SEG_SHIFT
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [2:0]                     mode_i,
    input  logic [2:0]                     base_sel_i,
    input  logic [P_REG_W-1:0]             base_val_i,
    input  logic [2:0]                     idx_sel_i,
    input  logic [P_REG_W-1:0]             idx_val_i,
    input  logic [P_OFS_W-1:0]             disp_i,
    input  logic [1:0]                     scale_i,
    input  logic                           ovr_valid_i,
    input  logic [2:0]                     ovr_seg_i,
    input  logic [P_SEG_W-1:0]             seg_es_i,
    input  logic [P_SEG_W-1:0]             seg_cs_i,
    input  logic [P_SEG_W-1:0]             seg_ss_i,
    input  logic [P_SEG_W-1:0]             seg_ds_i,
    input  logic [P_SEG_W-1:0]             seg_fs_i,
    input  logic [P_SEG_W-1:0]             seg_gs_i,
    output logic [P_OFS_W-1:0]             ea_o,
    output logic [2:0]                     seg_o,
    output logic [P_SEG_W+P_SEG_SHIFT-1:0] lin_o,
    output logic                           illegal_o
);

    localparam int LIN_W = P_SEG_W + P_SEG_SHIFT;

    ea_ctl_t               ctl;
    logic [P_OFS_W-1:0]    ea_c;
    logic                  ofs_bad;
    logic                  bp_used;
    logic [2:0]            seg_c;
    logic                  seg_bad;
    logic [LIN_W-1:0]      lin_c;
    logic [NSEG*P_SEG_W-1:0] seg_flat;
    logic                  any_bad;
    logic                  unused_hi_bits;

    assign ctl.mode  = mode_i;
    assign ctl.base  = greg_e'(base_sel_i);
    assign ctl.idx   = greg_e'(idx_sel_i);
    assign ctl.scale = scale_i;

    assign seg_flat = {seg_gs_i, seg_fs_i, seg_ds_i, seg_ss_i, seg_cs_i, seg_es_i};

    // upper register halves never reach the offset
    assign unused_hi_bits = ^{base_val_i[P_REG_W-1:P_OFS_W], idx_val_i[P_REG_W-1:P_OFS_W]};

    rmag_ofs_unit #(.P_OFS_W(P_OFS_W)) u_ofs (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .base_lo (base_val_i[P_OFS_W-1:0]),
        .idx_lo  (idx_val_i[P_OFS_W-1:0]),
        .disp    (disp_i),
        .ea      (ea_c),
        .bad     (ofs_bad),
        .bp_used (bp_used)
    );

    rmag_seg_pick u_seg (
        .clk       (clk),
        .rst       (rst),
        .bp_used   (bp_used),
        .ovr_valid (ovr_valid_i),
        .ovr_code  (ovr_seg_i),
        .seg_code  (seg_c),
        .bad       (seg_bad)
    );

    rmag_lin_add #(
        .P_OFS_W     (P_OFS_W),
        .P_SEG_W     (P_SEG_W),
        .P_SEG_SHIFT (P_SEG_SHIFT),
        .P_NSEG      (NSEG)
    ) u_lin (
        .clk      (clk),
        .rst      (rst),
        .seg_flat (seg_flat),
        .seg_code (seg_c),
        .ea       (ea_c),
        .lin      (lin_c)
    );

    assign any_bad = ofs_bad || seg_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_o      <= '0;
            seg_o     <= '0;
            lin_o     <= '0;
            illegal_o <= 1'b0;
        end else if (any_bad) begin
            ea_o      <= '0;
            seg_o     <= '0;
            lin_o     <= '0;
            illegal_o <= 1'b1;
        end else begin
            ea_o      <= ea_c;
            seg_o     <= seg_c;
            lin_o     <= lin_c;
            illegal_o <= 1'b0;
        end
    end

    // R10: a flagged request leaves every address output at zero
    p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (ea_o == '0 && seg_o == '0 && lin_o == '0));

    // R8: a legal override in a legal request names the output segment
    p_override_seg_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && ovr_valid_i) && !illegal_o) |-> (seg_o == $past(ovr_seg_i)));

    // R2: single-register offset equals the register's low half
    p_low_half_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && mode_i == AM_REG_IND && base_sel_i == GR_BX && !ovr_valid_i)
        |-> (ea_o == $past(base_val_i[P_OFS_W-1:0]) && !illegal_o));

    // R11: outputs are cleared after a reset cycle
    p_reset_clear_r11: assert property (@(posedge clk)
        $past(rst) |-> (lin_o == '0 && !illegal_o));

endmodule

// File: tb/rm_linaddr_gen_tb_top.sv
module rm_linaddr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = '0;
    logic [2:0]  base_sel_i = '0;
    logic [31:0] base_val_i = '0;
    logic [2:0]  idx_sel_i = '0;
    logic [31:0] idx_val_i = '0;
    logic [15:0] disp_i = '0;
    logic [1:0]  scale_i = '0;
    logic        ovr_valid_i = 1'b0;
    logic [2:0]  ovr_seg_i = '0;
    logic [15:0] seg_es_i = 16'h4000;
    logic [15:0] seg_cs_i = 16'h1000;
    logic [15:0] seg_ss_i = 16'h2000;
    logic [15:0] seg_ds_i = 16'h0B00;
    logic [15:0] seg_fs_i = 16'h5000;
    logic [15:0] seg_gs_i = 16'h6000;
    logic [15:0] ea_o;
    logic [2:0]  seg_o;
    logic [19:0] lin_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rm_linaddr_gen dut_i (
        .clk(clk), .rst(rst), .mode_i(mode_i), .base_sel_i(base_sel_i),
        .base_val_i(base_val_i), .idx_sel_i(idx_sel_i), .idx_val_i(idx_val_i),
        .disp_i(disp_i), .scale_i(scale_i), .ovr_valid_i(ovr_valid_i),
        .ovr_seg_i(ovr_seg_i), .seg_es_i(seg_es_i), .seg_cs_i(seg_cs_i),
        .seg_ss_i(seg_ss_i), .seg_ds_i(seg_ds_i), .seg_fs_i(seg_fs_i),
        .seg_gs_i(seg_gs_i), .ea_o(ea_o), .seg_o(seg_o), .lin_o(lin_o),
        .illegal_o(illegal_o)
    );

    task automatic check(string req, logic [15:0] e_ea, logic [2:0] e_seg,
                         logic [19:0] e_lin, logic e_ill);
        checks++;
        if (ea_o !== e_ea || seg_o !== e_seg || lin_o !== e_lin || illegal_o !== e_ill) begin
            errors++;
            $display("FAIL %s: actual ea=%h seg=%0d lin=%h ill=%b expected ea=%h seg=%0d lin=%h ill=%b",
                     req, ea_o, seg_o, lin_o, illegal_o, e_ea, e_seg, e_lin, e_ill);
        end
    endtask

    // present a request at a falling edge; it is registered on the next rise
    // and observed at the falling edge after that
    task automatic issue(logic [2:0] m, logic [2:0] bs, logic [31:0] bv,
                         logic [2:0] is, logic [31:0] iv, logic [15:0] d,
                         logic [1:0] sc, logic ov, logic [2:0] os);
        @(negedge clk);
        mode_i = m; base_sel_i = bs; base_val_i = bv; idx_sel_i = is;
        idx_val_i = iv; disp_i = d; scale_i = sc; ovr_valid_i = ov; ovr_seg_i = os;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 reset", 16'h0, 3'd0, 20'h0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_direct();
        seg_ds_i = 16'h1234;
        issue(3'd0, 3'd0, 32'h0, 3'd0, 32'h0, 16'h0022, 2'd0, 1'b0, 3'd0);
        check("R1 direct 1234:0022", 16'h0022, 3'd3, 20'h12362, 1'b0);
        // register fields filled with BP and junk must not matter
        issue(3'd0, 3'd5, 32'hDEAD_BEEF, 3'd4, 32'h1111_2222, 16'h0022, 2'd3, 1'b0, 3'd0);
        check("R12 direct ignores regs", 16'h0022, 3'd3, 20'h12362, 1'b0);
        seg_ds_i = 16'hFFFF;
        issue(3'd0, 3'd0, 32'h0, 3'd0, 32'h0, 16'h0020, 2'd0, 1'b0, 3'd0);
        check("R1 linear wrap", 16'h0020, 3'd3, 20'h00010, 1'b0);
        seg_ds_i = 16'h0B00;
    endtask

    task automatic t_low_half();
        issue(3'd5, 3'd4, 32'h0002_FF00, 3'd3, 32'h0, 16'h0, 2'd0, 1'b1, 3'd2);
        check("R2 low half of stack ptr", 16'hFF00, 3'd2, 20'h2FF00, 1'b0);
        issue(3'd1, 3'd3, 32'hABCD_1234, 3'd0, 32'h0, 16'h0, 2'd0, 1'b1, 3'd0);
        check("R8 ES override", 16'h1234, 3'd0, 20'h41234, 1'b0);
    endtask

    task automatic t_modes();
        issue(3'd4, 3'd3, 32'h0300, 3'd7, 32'h0200, 16'h0400, 2'd0, 1'b0, 3'd0);
        check("R3 base+idx+disp", 16'h0900, 3'd3, 20'h0B900, 1'b0);
        issue(3'd1, 3'd7, 32'h0200, 3'd0, 32'h0, 16'h0, 2'd0, 1'b0, 3'd0);
        check("R4 reg indirect DI", 16'h0200, 3'd3, 20'h0B200, 1'b0);
        issue(3'd1, 3'd0, 32'h0200, 3'd0, 32'h0, 16'h0, 2'd0, 1'b0, 3'd0);
        check("R4 reg indirect AX illegal", 16'h0, 3'd0, 20'h0, 1'b1);
        issue(3'd2, 3'd3, 32'h0300, 3'd6, 32'h0100, 16'h0, 2'd0, 1'b0, 3'd0);
        check("R5 base+idx BX SI", 16'h0400, 3'd3, 20'h0B400, 1'b0);
        issue(3'd2, 3'd6, 32'h0300, 3'd7, 32'h0100, 16'h0, 2'd0, 1'b0, 3'd0);
        check("R5 base SI illegal", 16'h0, 3'd0, 20'h0, 1'b1);
    endtask

    task automatic t_scaled();
        issue(3'd5, 3'd3, 32'h1000, 3'd6, 32'h0010, 16'h0, 2'd3, 1'b0, 3'd0);
        check("R6 scale 8", 16'h1080, 3'd3, 20'h0C080, 1'b0);
        issue(3'd5, 3'd3, 32'h1000, 3'd4, 32'h0010, 16'h0, 2'd1, 1'b0, 3'd0);
        check("R6 index SP illegal", 16'h0, 3'd0, 20'h0, 1'b1);
        issue(3'd5, 3'd3, 32'h0, 3'd5, 32'h0010, 16'h0, 2'd1, 1'b0, 3'd0);
        check("R7 BP as scaled index", 16'h0020, 3'd2, 20'h20020, 1'b0);
    endtask

    task automatic t_segments();
        issue(3'd3, 3'd5, 32'h0000_F000, 3'd0, 32'h0, 16'h0, 2'd0, 1'b0, 3'd0);
        check("R7 BP defaults to SS", 16'hF000, 3'd2, 20'h2F000, 1'b0);
        issue(3'd1, 3'd5, 32'h0100, 3'd0, 32'h0, 16'h0, 2'd0, 1'b1, 3'd1);
        check("R8 override beats BP", 16'h0100, 3'd1, 20'h10100, 1'b0);
        issue(3'd1, 3'd3, 32'h0100, 3'd0, 32'h0, 16'h0, 2'd0, 1'b1, 3'd6);
        check("R8 override code 6 illegal", 16'h0, 3'd0, 20'h0, 1'b1);
    endtask

    task automatic t_wrap_and_bad_mode();
        issue(3'd3, 3'd3, 32'h0000_FFF0, 3'd0, 32'h0, 16'h0020, 2'd0, 1'b0, 3'd0);
        check("R9 offset wrap", 16'h0010, 3'd3, 20'h0B010, 1'b0);
        issue(3'd7, 3'd3, 32'h0100, 3'd6, 32'h0, 16'h0, 2'd0, 1'b0, 3'd0);
        check("R10 mode 7 illegal", 16'h0, 3'd0, 20'h0, 1'b1);
        issue(3'd1, 3'd6, 32'h0100, 3'd0, 32'h0, 16'h0, 2'd0, 1'b0, 3'd0);
        check("R10 recovers after illegal", 16'h0100, 3'd3, 20'h0B100, 1'b0);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_low_half();
        t_modes();
        t_scaled();
        t_segments();
        t_wrap_and_bad_mode();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog: actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule